// File: doc/BRIEF.md
# Dual-Lane Continuous ADC Deserializer

This block reads a serial converter that samples without pause. It derives the converter's serial clock from the system clock with a programmable divider. The conversion rate follows that clock, so the divider is the only way to set the sample rate. The chip-select output is held active at all times. Word boundaries are therefore found only by counting falling edges of the serial clock from reset, or from a resync request.

Each channel word is 22 bits long and arrives MSB first. In one-lane mode every word comes in on data line 0, and a programmable number of channels (1 to 4) repeats in the fixed order A0, A1, B0, B1. In two-lane mode both lines shift at the same time. Line 0 carries A0 then A1, and line 1 carries B0 then B1, so the serial clock can run at half the rate for the same throughput. Each finished word leaves the block as a one-cycle valid pulse. The pulse carries a channel tag and the sample sign-extended to the output width.

Top module: `adc_lane_deser`

## Requirements
- R1: While reset is high and in the first cycle after it, `sclk` is 0 and `smp_valid` is 0.
- R2: Each phase of `sclk` lasts max(`cfg_half_div`, MIN_HALF) system cycles. MIN_HALF is the smallest half period that keeps `sclk` at or below SCLK_MAX_HZ. With the defaults (100 MHz, 20 MHz) MIN_HALF is 3, so settings 0, 1 and 2 give a 6-cycle period.
- R3: `cs_n` is 0 at all times.
- R4: Data is sampled on each falling edge of `sclk`. Every 22 sampled bits form one word, first bit most significant. Counting starts at the first falling edge after reset or resync.
- R5: In one-lane mode (`cfg_two_lane`=0), words are taken from `sdata[0]` and tagged with channels 0, 1, ... `cfg_nchan_m1` in turn, then wrap back to 0. The channel code is A0=0, A1=1, B0=2, B1=3.
- R6: In two-lane mode, each word slot yields two outputs on consecutive cycles. The lane 0 word comes first (code 0 in slot 0, code 1 in slot 1), then the lane 1 word (code 2, then code 3). The output order is 0, 2, 1, 3, repeating.
- R7: `smp_data` is the 22-bit word sign-extended to OUT_W bits. Bit 21 is the sign.
- R8: Every word produces exactly one cycle of `smp_valid`. In one-lane mode two valid cycles are never adjacent. In two-lane mode at most two are adjacent.
- R9: While `resync` is high, the bit count, the channel slot and any pending output are cleared and `smp_valid` is 0. Framing restarts at channel 0.
- R10: In one-lane mode, `sdata[1]` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| resync | input | 1 | Synchronous framing restart |
| cfg_two_lane | input | 1 | 1 = two data lines, 0 = one |
| cfg_nchan_m1 | input | 2 | Channels minus one in one-lane mode |
| cfg_half_div | input | DIV_W | Requested half period of sclk in system cycles |
| sclk | output | 1 | Serial clock to the converter |
| cs_n | output | 1 | Chip select, held low |
| sdata | input | 2 | Serial data lines (bit 0 = lane 0) |
| smp_valid | output | 1 | One-cycle sample strobe |
| smp_chan | output | 2 | Channel code of the sample |
| smp_data | output | OUT_W | Sign-extended sample |

## Verification
The assertions assume that the configuration inputs change only while `resync` is high. They also assume that `sdata` settles between a rising and the next falling edge of `sclk`, as a converter launching on the rising edge would provide. The stimulus holds resync for several cycles around every change of configuration. Its converter model updates the data lines only on the falling edge of `sclk`, after the block has taken its sample, and restarts its bit pointer while resync is high. Lane 1 is driven with the complement of lane 0 in one-lane mode, so any leakage from it shows up in the sample values.

// File: rtl/adc_deser_pkg.sv
package adc_deser_pkg;
  typedef enum logic [1:0] {
    CH_A0 = 2'd0,
    CH_A1 = 2'd1,
    CH_B0 = 2'd2,
    CH_B1 = 2'd3
  } chan_e;

  function automatic logic [1:0] lane_chan(input logic lane, input logic slot);
    return {lane, slot};
  endfunction
endpackage

// File: rtl/sclk_divider.sv
module sclk_divider #(
  parameter int DIV_W    = 8,
  parameter int MIN_HALF = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] half_cfg,
  output logic             sclk,
  output logic             fall_tick
);
  localparam logic [DIV_W-1:0] MIN_H = DIV_W'(MIN_HALF);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] eff_half;
  logic             sclk_q;
  logic             at_end;

  assign eff_half  = (half_cfg < MIN_H) ? MIN_H : half_cfg;
  assign at_end    = (cnt_q >= eff_half - 1'b1);
  assign fall_tick = at_end && sclk_q;
  assign sclk      = sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (at_end) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  // phase-length monitor for the rate check
  logic             sclk_prev;
  logic [DIV_W:0]   hold_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev <= 1'b0;
      hold_q    <= '0;
    end else begin
      sclk_prev <= sclk_q;
      hold_q    <= (sclk_q != sclk_prev) ? (DIV_W+1)'(2) : hold_q + 1'b1;
    end
  end

  AST_SCLK_RATE: assert property (@(posedge clk) disable iff (rst)
    (sclk_q != sclk_prev) |-> (hold_q >= (DIV_W+1)'(MIN_HALF))); // R2
endmodule

// File: rtl/lane_shifter.sv
module lane_shifter #(
  parameter int WORD_BITS = 22
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clear,
  input  logic                 shift_en,
  input  logic                 sd,
  output logic [WORD_BITS-1:0] word
);
  logic [WORD_BITS-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sr_q <= '0;
    end else if (shift_en) begin
      sr_q <= {sr_q[WORD_BITS-2:0], sd};
    end
  end

  assign word = sr_q;

  AST_SHIFT_IN_LSB: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !clear) |=> (word[0] == $past(sd))); // R4
endmodule

// File: rtl/adc_lane_deser.sv
module adc_lane_deser #(
  parameter int SYS_CLK_HZ  = 100_000_000,
  parameter int SCLK_MAX_HZ = 20_000_000,
  parameter int DIV_W       = 8,
  parameter int WORD_BITS   = 22,
  parameter int OUT_W       = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             resync,
  input  logic             cfg_two_lane,
  input  logic [1:0]       cfg_nchan_m1,
  input  logic [DIV_W-1:0] cfg_half_div,
  output logic             sclk,
  output logic             cs_n,
  input  logic [1:0]       sdata,
  output logic             smp_valid,
  output logic [1:0]       smp_chan,
  output logic [OUT_W-1:0] smp_data
);
  import adc_deser_pkg::*;

  localparam int N_LANES  = 2;
  localparam int MIN_HALF = (SYS_CLK_HZ + 2*SCLK_MAX_HZ - 1) / (2*SCLK_MAX_HZ);
  localparam int BIT_W    = $clog2(WORD_BITS);
  localparam int EXT_W    = OUT_W - WORD_BITS;

  logic                 fall_tick;
  logic [WORD_BITS-1:0] lane_word [N_LANES];

  assign cs_n = 1'b0;

  sclk_divider #(.DIV_W(DIV_W), .MIN_HALF(MIN_HALF)) i_div (
    .clk       (clk),
    .rst       (rst),
    .half_cfg  (cfg_half_div),
    .sclk      (sclk),
    .fall_tick (fall_tick)
  );

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    lane_shifter #(.WORD_BITS(WORD_BITS)) i_lane (
      .clk      (clk),
      .rst      (rst),
      .clear    (resync),
      .shift_en (fall_tick),
      .sd       (sdata[g]),
      .word     (lane_word[g])
    );
  end

  function automatic logic [OUT_W-1:0] sext(input logic [WORD_BITS-1:0] w);
    return {{EXT_W{w[WORD_BITS-1]}}, w};
  endfunction

  // framing: bit count and channel slot
  logic [BIT_W-1:0] bitcnt_q;
  logic [1:0]       slot_q;
  logic [1:0]       last_slot;
  logic             done_q;
  logic [1:0]       done_slot_q;

  assign last_slot = cfg_two_lane ? 2'd1 : cfg_nchan_m1;

  always_ff @(posedge clk) begin
    if (rst || resync) begin
      bitcnt_q    <= '0;
      slot_q      <= '0;
      done_q      <= 1'b0;
      done_slot_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (fall_tick) begin
        if (bitcnt_q == BIT_W'(WORD_BITS-1)) begin
          bitcnt_q    <= '0;
          done_q      <= 1'b1;
          done_slot_q <= slot_q;
          slot_q      <= (slot_q >= last_slot) ? 2'd0 : slot_q + 2'd1;
        end else begin
          bitcnt_q <= bitcnt_q + 1'b1;
        end
      end
    end
  end

  // output stage: lane 0 word first, lane 1 word one cycle later
  logic       pend_q;
  logic [1:0] pend_chan_q;

  always_ff @(posedge clk) begin
    if (rst || resync) begin
      smp_valid   <= 1'b0;
      smp_chan    <= CH_A0;
      smp_data    <= '0;
      pend_q      <= 1'b0;
      pend_chan_q <= '0;
    end else begin
      smp_valid <= 1'b0;
      pend_q    <= 1'b0;
      if (done_q) begin
        smp_valid   <= 1'b1;
        smp_chan    <= cfg_two_lane ? lane_chan(1'b0, done_slot_q[0]) : done_slot_q;
        smp_data    <= sext(lane_word[0]);
        pend_q      <= cfg_two_lane;
        pend_chan_q <= lane_chan(1'b1, done_slot_q[0]);
      end else if (pend_q) begin
        smp_valid <= 1'b1;
        smp_chan  <= pend_chan_q;
        smp_data  <= sext(lane_word[1]);
      end
    end
  end

  AST_BIT_RANGE: assert property (@(posedge clk) disable iff (rst)
    bitcnt_q < BIT_W'(WORD_BITS)); // R4
  AST_CHAN_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !cfg_two_lane) |-> (smp_chan <= cfg_nchan_m1)); // R5
  AST_B_AFTER_A: assert property (@(posedge clk) disable iff (rst || resync)
    (smp_valid && cfg_two_lane && !smp_chan[1]) |=>
      (smp_valid && smp_chan == {1'b1, $past(smp_chan[0])})); // R6
  AST_SIGN_EXT: assert property (@(posedge clk) disable iff (rst)
    smp_valid |-> ((&smp_data[OUT_W-1:WORD_BITS-1]) || !(|smp_data[OUT_W-1:WORD_BITS-1]))); // R7
  AST_ONE_LANE_PULSE: assert property (@(posedge clk) disable iff (rst || resync)
    (smp_valid && !cfg_two_lane) |=> !smp_valid); // R8
  AST_RESYNC_QUIET: assert property (@(posedge clk) disable iff (rst)
    resync |=> !smp_valid); // R9
endmodule

// File: tb/test_adc_lane_deser.sv
module test_adc_lane_deser;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;

  // {two_lane, nchan_m1, half, w0, w1, w2, w3}
  localparam logic [98:0] VEC [NV] = '{
    {1'b0, 2'd0, 8'd5, 22'h2ABCDE, 22'h000000, 22'h000000, 22'h000000},
    {1'b0, 2'd3, 8'd3, 22'h000001, 22'h3FFFFF, 22'h1FFFFF, 22'h200000},
    {1'b1, 2'd3, 8'd4, 22'h123456, 22'h2468AC, 22'h0F0F0F, 22'h30F0F0},
    {1'b1, 2'd3, 8'd1, 22'h3C3C3C, 22'h055555, 22'h2AAAAA, 22'h000000},
    {1'b0, 2'd1, 8'd0, 22'h155555, 22'h2FEDCB, 22'h000000, 22'h000000},
    {1'b0, 2'd2, 8'd7, 22'h000000, 22'h3ABCDE, 22'h00FFFF, 22'h000000}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       resync = 1'b0;
  logic       cfg_two_lane = 1'b0;
  logic [1:0] cfg_nchan_m1 = 2'd0;
  logic [7:0] cfg_half_div = 8'd3;
  logic       sclk, cs_n, smp_valid;
  logic [1:0] sdata, smp_chan;
  logic [23:0] smp_data;

  int tests = 0, fails = 0;
  logic [87:0] l0 = '0, l1 = '0;
  int ptr = 0, flen = 22;

  adc_lane_deser i_adc_lane_deser (
    .clk(clk), .rst(rst), .resync(resync), .cfg_two_lane(cfg_two_lane),
    .cfg_nchan_m1(cfg_nchan_m1), .cfg_half_div(cfg_half_div), .sclk(sclk),
    .cs_n(cs_n), .sdata(sdata), .smp_valid(smp_valid), .smp_chan(smp_chan),
    .smp_data(smp_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // converter model: presents bit ptr, advances after each falling sclk edge
  assign sdata = {l1[87-ptr], l0[87-ptr]};
  always @(negedge sclk) begin
    if (rst || resync) ptr = 0;
    else ptr = (ptr + 1) % flen;
  end

  // output monitor
  int cyc = 0, last_rise = 0, rise_gap = 0, n = 0, run = 0, width_err = 0, cs_err = 0;
  logic prev_sclk = 1'b0;
  logic [1:0]  got_ch [32];
  logic [23:0] got_d  [32];
  always @(negedge clk) begin
    cyc++;
    if (sclk && !prev_sclk) begin
      rise_gap = cyc - last_rise;
      last_rise = cyc;
    end
    prev_sclk = sclk;
    if (cs_n !== 1'b0) cs_err++;
    if (smp_valid === 1'b1) begin
      if (n < 32) begin
        got_ch[n] = smp_chan;
        got_d[n] = smp_data;
      end
      n++;
      run++;
      if (run > (cfg_two_lane ? 2 : 1)) width_err++;
    end else begin
      run = 0;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] sx(input logic [21:0] w);
    return {{2{w[21]}}, w};
  endfunction

  function automatic logic [21:0] word_of(input logic [98:0] v, input int c);
    return v[87-22*c -: 22];
  endfunction

  task automatic load_cfg(input logic [98:0] v);
    resync = 1'b1;
    repeat (2) @(negedge clk);
    cfg_two_lane = v[98];
    cfg_nchan_m1 = v[97:96];
    cfg_half_div = v[95:88];
    if (v[98]) begin
      l0 = {v[87:44], 44'd0};
      l1 = {v[43:0], 44'd0};
      flen = 44;
    end else begin
      l0 = v[87:0];
      l1 = ~v[87:0];
      flen = 22 * (int'(v[97:96]) + 1);
    end
    repeat (3) @(negedge clk);
    n = 0;
    width_err = 0;
    resync = 1'b0;
  endtask

  task automatic wait_outputs(input int cnt);
    for (int t = 0; t < 30000 && n < cnt; t++) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // reset state: R1, R3
    repeat (5) @(negedge clk);
    check(sclk === 1'b0, "R1 sclk in reset", 32'(sclk), 0);
    check(smp_valid === 1'b0, "R1 valid in reset", 32'(smp_valid), 0);
    check(cs_n === 1'b0, "R3 cs_n in reset", 32'(cs_n), 0);
    rst = 1'b0;
    @(negedge clk);
    check(sclk === 1'b0, "R1 sclk after reset", 32'(sclk), 0);
    check(smp_valid === 1'b0, "R1 valid after reset", 32'(smp_valid), 0);

    // table walk: R2, R4, R5, R6, R7, R8, R10
    for (int v = 0; v < NV; v++) begin
      int nexp;
      int hexp;
      load_cfg(VEC[v]);
      nexp = VEC[v][98] ? 8 : 2 * (int'(VEC[v][97:96]) + 1);
      wait_outputs(nexp);
      check(n >= nexp, "R4 word count", 32'(n), 32'(nexp));
      for (int k = 0; k < nexp; k++) begin
        int ch;
        if (VEC[v][98]) ch = (k % 4 == 0) ? 0 : (k % 4 == 1) ? 2 : (k % 4 == 2) ? 1 : 3;
        else ch = k % (int'(VEC[v][97:96]) + 1);
        if (VEC[v][98])
          check(got_ch[k] == 2'(ch), "R6 channel order", 32'(got_ch[k]), 32'(ch));
        else
          check(got_ch[k] == 2'(ch), "R5 channel order", 32'(got_ch[k]), 32'(ch));
        check(got_d[k] == sx(word_of(VEC[v], ch)), "R4/R7/R10 sample value",
              32'(got_d[k]), 32'(sx(word_of(VEC[v], ch))));
      end
      hexp = (VEC[v][95:88] < 8'd3) ? 3 : int'(VEC[v][95:88]);
      check(rise_gap == 2 * hexp, "R2 sclk period", 32'(rise_gap), 32'(2 * hexp));
      check(width_err == 0, "R8 valid pulse width", 32'(width_err), 0);
    end

    // resync in the middle of a word: R9
    load_cfg(VEC[1]);
    repeat (40) @(negedge clk);
    resync = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(smp_valid === 1'b0, "R9 quiet during resync", 32'(smp_valid), 0);
    n = 0;
    repeat (2) @(negedge clk);
    resync = 1'b0;
    wait_outputs(4);
    check(n >= 4, "R9 words after resync", 32'(n), 4);
    for (int k = 0; k < 4; k++) begin
      check(got_ch[k] == 2'(k), "R9 restart channel", 32'(got_ch[k]), 32'(k));
      check(got_d[k] == sx(word_of(VEC[1], k)), "R9 restart data",
            32'(got_d[k]), 32'(sx(word_of(VEC[1], k))));
    end

    check(cs_err == 0, "R3 cs_n held low", 32'(cs_err), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule